// File: doc/BRIEF.md
# Chained-Channel Ring Capture Engine

This block streams 32-bit samples from a paced producer into a memory ring that is built from several equal segments, each owned by its own write channel. Exactly one channel is active at a time. The active channel writes accepted samples to consecutive words of its segment. When it writes the final word of that segment, it passes control to the next channel. The last channel passes control back to the first, so the ring keeps overwriting its oldest data with no software involvement.

Each channel wraps within its own segment by masking the low address bits. Because of this, the base address only needs to be aligned to one segment, not to the whole ring. The segments sit back to back in memory above that base. Capture runs until software stops it, and the producer alone decides how many samples arrive. A start pulse loads the base and restarts the ring at channel 0. A stop request halts capture once the write in progress is done. A status port shows the active channel and the address of the next write.

Top module: `ringcap_dma`

## Requirements
- R1: After reset the engine is idle: `smpReady` and `memWe` are 0, `activeCh` is 0 and `wrPtr` is 0.
- R2: A `startPulse` stores `baseAddr` with its low log2(segment bytes) bits forced to zero. From the next cycle the engine runs with channel 0 at word 0, so `wrPtr` equals that aligned base.
- R3: A sample is accepted in a cycle when `smpValid` and `smpReady` are both high. In that same cycle `memWe` is 1 and `memData` equals `smpData`. The write pointer of the active channel then advances by 4 bytes.
- R4: Channel i writes only inside its own segment, whose byte addresses run from base + i*SEG_BYTES up to base + (i+1)*SEG_BYTES - 4. The segments are contiguous.
- R5: In the cycle after a channel writes its final segment word, the next channel becomes active at the start of its segment. `smpReady` stays high through this handoff, so no sample is lost.
- R6: The last channel hands off to channel 0. The next write then lands at the aligned base and overwrites the oldest data.
- R7: In a cycle with `smpValid` low, nothing is written and neither `activeCh` nor `wrPtr` changes.
- R8: When `stopReq` is high while running, the write of that cycle still completes. From the next cycle `smpReady` and `memWe` stay 0 until the next start.
- R9: A start pulse, whether issued while running or in the same cycle as `stopReq`, restarts at channel 0, word 0, with the new base. Start takes priority over stop.
- R10: If a stop coincides with the final word of a segment, that word is written and the handoff still takes place. The engine then halts with `activeCh` showing the next channel and `wrPtr` at the start of that channel's segment.
- R11: `wrPtr` always shows the address the next accepted sample will be written to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Load base and restart the ring at channel 0 |
| stopReq | input | 1 | Halt capture after the current write |
| baseAddr | input | ADDR_W | Ring base byte address (segment alignment applied) |
| smpValid | input | 1 | Producer has a sample |
| smpData | input | DATA_W | Sample word |
| smpReady | output | 1 | Engine accepts samples (running) |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | DATA_W | Write data |
| memWe | output | 1 | Write strobe |
| activeCh | output | log2(NUM_CH) | Index of the active channel |
| wrPtr | output | ADDR_W | Address of the next write |

## Verification
The collision of interest is a stop request in the same cycle as the final word of a segment. In that cycle the halt and the channel handoff both act on the control state. The bench feeds samples until its model sits on the last word of a segment, then raises stop together with a valid sample. It expects the word to be written, the next channel to show on `activeCh`, `wrPtr` to sit at that channel's segment start, and `smpReady` to fall. A second directed case raises start and stop together and expects start to win. Random stop and start pulses add further coincidences of this kind.

// File: rtl/ringcap_pkg.sv
package ringcap_pkg;
  typedef struct packed {
    logic restart;
    logic accept;
  } ctlStrobes_t;
endpackage

// File: rtl/ringcap_ctrl.sv
module ringcap_ctrl
  import ringcap_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            stopReq,
  input  logic            smpValid,
  input  logic            segLast,
  output ctlStrobes_t     strobes,
  output logic [CH_W-1:0] activeCh,
  output logic            running
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic accept;
  logic handoff;

  always_comb begin
    accept          = running & smpValid;
    handoff         = accept & segLast;
    strobes.restart = startPulse;
    strobes.accept  = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      activeCh <= '0;
    end else if (startPulse) begin
      running  <= 1'b1;
      activeCh <= '0;
    end else begin
      if (handoff) activeCh <= (activeCh == LAST_CH) ? '0 : activeCh + CH_W'(1);
      if (stopReq) running <= 1'b0;
    end
  end

  assert_handoff_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    (handoff && !startPulse && activeCh != LAST_CH) |=> activeCh == $past(activeCh) + CH_W'(1));
  assert_ring_close_R6: assert property (@(posedge clk) disable iff (!rstN)
    (handoff && !startPulse && activeCh == LAST_CH) |=> activeCh == '0);
  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startPulse) |=> !running);
  assert_start_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (running && activeCh == '0));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!accept && !startPulse) |=> $stable(activeCh));
endmodule

// File: rtl/ringcap_datapath.sv
module ringcap_datapath
  import ringcap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int SEG_WORDS = 8192,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int OFF_W     = $clog2(SEG_WORDS),
  localparam int SEG_BYTES = SEG_WORDS * 4,
  localparam int SEG_SH    = $clog2(SEG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CH_W-1:0]   chIdx,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [DATA_W-1:0] smpData,
  output logic              segLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memWe,
  output logic [ADDR_W-1:0] wrPtr
);
  logic [ADDR_W-1:0]            baseReg;
  logic [NUM_CH-1:0][OFF_W-1:0] offs;
  logic [OFF_W-1:0]             curOff;
  logic [ADDR_W-1:0]            segBase;

  always_ff @(posedge clk) begin
    if (!rstN) baseReg <= '0;
    else if (strobes.restart) baseReg <= {baseIn[ADDR_W-1:SEG_SH], SEG_SH'(0)};
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [OFF_W-1:0] chOff;
    always_ff @(posedge clk) begin
      if (!rstN) chOff <= '0;
      else if (strobes.restart) chOff <= '0;
      else if (strobes.accept && chIdx == CH_W'(g)) chOff <= chOff + OFF_W'(1);
    end
    assign offs[g] = chOff;
  end

  always_comb begin
    curOff  = offs[chIdx];
    segLast = (curOff == OFF_W'(SEG_WORDS - 1));
    segBase = baseReg + (ADDR_W'(chIdx) << SEG_SH);
    wrPtr   = segBase + (ADDR_W'(curOff) << 2);
    memAddr = wrPtr;
    memData = smpData;
    memWe   = strobes.accept;
  end

  assert_word_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && !segLast && !strobes.restart) |=> wrPtr == $past(wrPtr) + ADDR_W'(4));
  assert_seg_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && segLast && !strobes.restart) |=> wrPtr[SEG_SH-1:0] == '0);
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accept && !strobes.restart) |=> $stable(wrPtr));
endmodule

// File: rtl/ringcap_dma.sv
module ringcap_dma
  import ringcap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int SEG_WORDS = 8192,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopReq,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              smpValid,
  input  logic [DATA_W-1:0] smpData,
  output logic              smpReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memWe,
  output logic [CH_W-1:0]   activeCh,
  output logic [ADDR_W-1:0] wrPtr
);
  ctlStrobes_t strobes;
  logic        segLast;
  logic        running;

  ringcap_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopReq(stopReq),
    .smpValid(smpValid), .segLast(segLast), .strobes(strobes),
    .activeCh(activeCh), .running(running)
  );

  ringcap_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .SEG_WORDS(SEG_WORDS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chIdx(activeCh),
    .baseIn(baseAddr), .smpData(smpData), .segLast(segLast),
    .memAddr(memAddr), .memData(memData), .memWe(memWe), .wrPtr(wrPtr)
  );

  assign smpReady = running;

  assert_no_idle_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !smpReady |-> !memWe);
  assert_write_is_ptr_R11: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == wrPtr);
endmodule

// File: tb/ringcap_dma_test.sv
module ringcap_dma_test;
  localparam int NCH = 4;
  localparam int SEGW = 16;
  localparam int SEGB = SEGW * 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, stopReq = 1'b0, smpValid = 1'b0;
  logic [31:0] baseAddr = '0, smpData = '0;
  logic smpReady, memWe;
  logic [31:0] memAddr, memData, wrPtr;
  logic [1:0] activeCh;

  int checks = 0;
  int errors = 0;

  logic mRun = 1'b0;
  int mCh = 0;
  int mOff = 0;
  logic [31:0] mBase = '0;

  always #4 clk = ~clk;

  ringcap_dma #(.ADDR_W(32), .DATA_W(32), .NUM_CH(NCH), .SEG_WORDS(SEGW)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopReq(stopReq),
    .baseAddr(baseAddr), .smpValid(smpValid), .smpData(smpData),
    .smpReady(smpReady), .memAddr(memAddr), .memData(memData), .memWe(memWe),
    .activeCh(activeCh), .wrPtr(wrPtr)
  );

  function automatic logic [31:0] expAddr();
    return mBase + 32'(mCh * SEGB) + 32'(mOff * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] d, input logic st,
                      input logic sp, input logic [31:0] b, input string tag);
    @(negedge clk);
    smpValid = v; smpData = d; startPulse = st; stopReq = sp; baseAddr = b;
    #2;
    chk("R8 ready", 32'(smpReady), 32'(mRun));
    chk("R7 write strobe", 32'(memWe), 32'(mRun & v));
    if (mRun && v) begin
      chk("R4 address", memAddr, expAddr());
      chk("R3 data", memData, d);
    end
    chk({tag, " channel"}, 32'(activeCh), 32'(mCh));
    chk({tag, " R11 pointer"}, wrPtr, expAddr());
    @(posedge clk);
    if (st) begin
      mRun = 1'b1; mCh = 0; mOff = 0; mBase = b & ~32'(SEGB - 1);
    end else begin
      if (mRun && v) begin
        if (mOff == SEGW - 1) begin
          mOff = 0; mCh = (mCh + 1) % NCH;
        end else mOff++;
      end
      if (sp) mRun = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", 32'(smpReady), 0);
    chk("R1 strobe", 32'(memWe), 0);
    chk("R1 channel", 32'(activeCh), 0);
    chk("R1 pointer", wrPtr, 0);
    rstN = 1'b1;

    // unaligned base is trimmed to segment alignment
    step(1'b0, 0, 1'b1, 1'b0, 32'h2000_1234, "R2");
    step(1'b1, 32'hA5A5_0000, 1'b0, 1'b0, 0, "R2");
    // full ring traversal with continuous valid
    for (int i = 0; i < NCH * SEGW - 1; i++)
      step(1'b1, 32'h1000 + 32'(i), 1'b0, 1'b0, 0, "R5");
    step(1'b1, 32'hBEEF_0001, 1'b0, 1'b0, 0, "R6");
    // gaps in valid
    step(1'b0, 0, 1'b0, 1'b0, 0, "R7");
    step(1'b0, 0, 1'b0, 1'b0, 0, "R7");
    // stop on the final word of a segment
    while (mOff != SEGW - 1) step(1'b1, $urandom, 1'b0, 1'b0, 0, "R5");
    step(1'b1, 32'hCAFE_F00D, 1'b0, 1'b1, 0, "R10");
    step(1'b1, 32'h0, 1'b0, 1'b0, 0, "R10");
    step(1'b1, 32'h1, 1'b0, 1'b0, 0, "R8");
    // start and stop together: start wins
    step(1'b0, 0, 1'b1, 1'b1, 32'h0000_8040, "R9");
    step(1'b1, 32'h77, 1'b0, 1'b0, 0, "R9");
    // restart while running
    step(1'b1, 32'h78, 1'b1, 1'b0, 32'h0001_0000, "R9");
    step(1'b1, 32'h79, 1'b0, 1'b0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      logic v, st, sp;
      v  = ($urandom % 10) < 7;
      sp = ($urandom % 200) == 0;
      st = !mRun ? (($urandom % 8) == 0) : (($urandom % 300) == 0);
      step(v, $urandom, st, sp, $urandom, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule